// File: doc/BRIEF.md
# Endian-Selectable Aligned Load/Store Unit

This block sits between the memory stage of a processor pipeline and a 32-bit wide, word-addressed data memory. Each request carries a byte address, an access width (byte, halfword or word), store data, a signed/unsigned flag for loads, and a per-request byte-order select. The block decides whether the access is naturally aligned. Misaligned accesses are not split or repaired. They raise a one-cycle trap and latch the faulting address, and they never reach memory.

For aligned stores the block steers the value onto the four memory byte lanes and drives matching byte enables. Either byte order is applied per request. For aligned loads it reads the memory word the same cycle, picks the addressed lanes in the chosen byte order, and sign- or zero-extends the result. The result goes to a register that is qualified by a one-cycle valid strobe. Memory lane k (bits 8k+7:8k) holds the byte whose address has low bits equal to k.

Top module: `lsu_endian_align`

## Requirements
- R1: The size code is 2'b00 for byte, 2'b01 for halfword, 2'b10 for word, and 2'b11 is invalid. Byte accesses are always aligned. A halfword is aligned only when address bit 0 is 0. A word is aligned only when address bits 1:0 are 00. An invalid size is always treated as misaligned.
- R2: A misaligned request drives mem_en low and mem_be to 0000, so no memory write occurs. It produces no ld_valid. In the cycle after it, trap is high for exactly one cycle.
- R3: On a trap, trap_addr takes the full 32-bit request address. trap_addr keeps that value until the next trap.
- R4: An aligned byte store drives exactly one byte enable, at lane addr[1:0]. That lane carries wdata[7:0] in either byte order.
- R5: An aligned halfword store enables lanes 1:0 when addr[1] is 0 and lanes 3:2 when addr[1] is 1. In little-endian mode (big=0) the lower lane gets wdata[7:0] and the upper lane gets wdata[15:8]. In big-endian mode (big=1) the two are swapped.
- R6: An aligned word store enables all four lanes. In little-endian mode lane k gets wdata byte k. In big-endian mode lane k gets wdata byte 3-k.
- R7: Loads select lanes by the same rules as stores in R4 to R6, so a value stored and then loaded back with the same size and byte order comes back unchanged. Loads drive mem_en high, mem_we low and mem_be 0000.
- R8: When the signed flag is 1, byte and halfword load results are sign-extended to 32 bits. When it is 0, they are zero-extended.
- R9: ld_valid is high for exactly one cycle, in the cycle after an aligned load request, and ld_data holds the result in that cycle.
- R10: While reset is high, and in the first cycle after it, ld_valid and trap are 0 and trap_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (R1) |
| req_signed | input | 1 | Sign-extend load result |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store value, right-aligned |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Per-lane byte write enables |
| mem_addr | output | AW | Word address (req_addr[AW+1:2]) |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Memory word, combinational read of mem_addr |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | 32 | Extended load result |
| trap | output | 1 | Misalignment trap pulse |
| trap_addr | output | 32 | Address of the last faulting access |

## Verification
Random traffic mixes every size code, both byte orders, both extension modes and every low address pattern over a small address window. Reusing addresses lets later loads expose any wrong byte placed by an earlier store. Loads that read back stores of a different width or byte order separate true lane mirroring from a simple byte swap. Directed cases cover the odd halfword offsets, word offsets 1 to 3, and the invalid size, and they show whether a trap writes memory or only drops it. Loads of bytes with the top bit set and with it clear tell sign extension apart from zero extension.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;

  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;
  localparam int OFF_W  = $clog2(LANES);
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] off,
  output logic             aligned
);
  always_comb begin
    unique case (size)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = ~off[0];
      SZ_WORD: aligned = (off == '0);
      default: aligned = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic              big,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lanes
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HLE = k % 2;
    localparam int HBE = 1 - (k % 2);
    localparam int WLE = k;
    localparam int WBE = LANES - 1 - k;
    localparam logic [OFF_W-1:0] KOFF = OFF_W'(k);
    logic [7:0] sel;
    logic       hit;

    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          sel = wdata[7:0];
          hit = (off == KOFF);
        end
        SZ_HALF: begin
          sel = big ? wdata[HBE*8 +: 8] : wdata[HLE*8 +: 8];
          hit = (off[1] == KOFF[1]);
        end
        SZ_WORD: begin
          sel = big ? wdata[WBE*8 +: 8] : wdata[WLE*8 +: 8];
          hit = 1'b1;
        end
        default: begin
          sel = 8'h00;
          hit = 1'b0;
        end
      endcase
    end

    assign lanes[k*8 +: 8] = sel;
    assign be[k]           = en & hit;
  end

  // R4
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (en && size == SZ_BYTE) |-> ($countones(be) == 1 && be[off]));
  // R6
  word_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (en && size == SZ_WORD) |-> (be == '1));
endmodule

// File: rtl/lsu_load_unpack.sv
module lsu_load_unpack
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic              big,
  input  logic              sgn,
  output logic [DATA_W-1:0] value
);
  logic [7:0]  ln [LANES];
  logic [DATA_W-1:0] swapped;

  for (genvar k = 0; k < LANES; k++) begin : g_split
    assign ln[k] = rdata[k*8 +: 8];
    assign swapped[k*8 +: 8] = rdata[(LANES-1-k)*8 +: 8];
  end

  logic [OFF_W-1:0] lo_i, hi_i;
  logic [7:0]  b_val;
  logic [15:0] h_val;

  always_comb begin
    lo_i  = {off[1], 1'b0};
    hi_i  = {off[1], 1'b1};
    b_val = ln[off];
    h_val = big ? {ln[lo_i], ln[hi_i]} : {ln[hi_i], ln[lo_i]};
    unique case (size)
      SZ_BYTE: value = {{(DATA_W-8){sgn & b_val[7]}}, b_val};
      SZ_HALF: value = {{(DATA_W-16){sgn & h_val[15]}}, h_val};
      SZ_WORD: value = big ? swapped : rdata;
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/lsu_endian_align.sv
module lsu_endian_align
  import lsu_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_big,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              ld_valid,
  output logic [31:0]       ld_data,
  output logic              trap,
  output logic [31:0]       trap_addr
);
  logic [OFF_W-1:0]  off;
  logic              aligned;
  logic              st_go;
  logic [DATA_W-1:0] ld_next;

  assign off = req_addr[OFF_W-1:0];

  lsu_align_chk u_align (
    .size    (req_size),
    .off     (off),
    .aligned (aligned)
  );

  assign st_go = req_valid & req_write & aligned;

  lsu_store_pack u_pack (
    .clk   (clk),
    .rst   (rst),
    .en    (st_go),
    .size  (req_size),
    .off   (off),
    .big   (req_big),
    .wdata (req_wdata),
    .be    (mem_be),
    .lanes (mem_wdata)
  );

  lsu_load_unpack u_unpack (
    .rdata (mem_rdata),
    .size  (req_size),
    .off   (off),
    .big   (req_big),
    .sgn   (req_signed),
    .value (ld_next)
  );

  assign mem_en   = req_valid & aligned;
  assign mem_we   = st_go;
  assign mem_addr = req_addr[AW+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      trap      <= 1'b0;
      trap_addr <= '0;
    end else begin
      ld_valid <= req_valid & ~req_write & aligned;
      trap     <= req_valid & ~aligned;
      if (req_valid & ~req_write & aligned) ld_data <= ld_next;
      if (req_valid & ~aligned) trap_addr <= req_addr;
    end
  end

  // R1
  half_odd_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == SZ_HALF && req_addr[0]) |=> trap);
  // R2
  trap_blocks_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !aligned) |-> (!mem_en && mem_be == '0));
  // R2
  trap_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> !ld_valid);
  // R3
  trap_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!trap && $past(!rst)) |=> (trap || $stable(trap_addr)) || $past(rst));
  // R7
  load_no_be_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |-> (mem_be == '0 && !mem_we));
  // R8
  byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == SZ_BYTE && !req_signed)
      |=> (ld_data[31:8] == '0));
  // R9
  ld_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(req_valid && !req_write));
endmodule

// File: tb/lsu_endian_align_tb_top.sv
module lsu_endian_align_tb_top;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_signed, req_big;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        mem_en, mem_we;
  logic [3:0]  mem_be;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        ld_valid, trap;
  logic [31:0] ld_data, trap_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] ram [0:(1<<AW)-1];
  logic [7:0]  sh  [0:(4<<AW)-1];

  always #5 clk = ~clk;

  lsu_endian_align #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_big(req_big),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data), .trap(trap), .trap_addr(trap_addr)
  );

  assign mem_rdata = ram[mem_addr];
  always @(posedge clk)
    if (mem_en && mem_we)
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) ram[mem_addr][k*8 +: 8] <= mem_wdata[k*8 +: 8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_aligned(input logic [1:0] sz, input logic [1:0] o);
    case (sz)
      2'b00: return 1'b1;
      2'b01: return o[0] == 1'b0;
      2'b10: return o == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  // byte i of the value (i = 0 is least significant) goes to address base+pos
  function automatic int pos_of(input int i, input int n, input bit big);
    return big ? (n - 1 - i) : i;
  endfunction

  function automatic logic [31:0] exp_load(input logic [11:0] a, input logic [1:0] sz,
                                           input bit big, input bit sgn);
    int n = nbytes(sz);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[i*8 +: 8] = sh[a + 12'(pos_of(i, n, big))];
    if (sgn && n == 1 && v[7])  v[31:8]  = '1;
    if (sgn && n == 2 && v[15]) v[31:16] = '1;
    return v;
  endfunction

  task automatic access(input bit wr, input logic [1:0] sz, input bit sgn,
                        input bit big, input logic [31:0] a, input logic [31:0] wd);
    bit ok = is_aligned(sz, a[1:0]);
    int n = nbytes(sz);
    logic [3:0]  ebe = '0;
    logic [31:0] eld;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_signed = sgn;
    req_big = big; req_addr = a; req_wdata = wd;
    #1;
    chk("R9 ld_valid single cycle", 32'(ld_valid), 0);
    chk("R1/R2 mem_en", 32'(mem_en), 32'(ok));
    eld = exp_load(a[11:0], sz, big, sgn);
    if (ok && wr) begin
      for (int i = 0; i < n; i++) begin
        int ln = int'(a[1:0]) + pos_of(i, n, big);
        ebe[ln] = 1'b1;
        chk(sz == 0 ? "R4 lane data" : sz == 1 ? "R5 lane data" : "R6 lane data",
            32'(mem_wdata[ln*8 +: 8]), 32'(wd[i*8 +: 8]));
      end
      chk(sz == 0 ? "R4 be" : sz == 1 ? "R5 be" : "R6 be", 32'(mem_be), 32'(ebe));
    end else if (!ok) begin
      chk("R2 be zero on trap", 32'(mem_be), 0);
    end else begin
      chk("R7 load be/we", {27'd0, mem_be, mem_we}, 0);
    end
    @(posedge clk);
    if (ok && wr)
      for (int i = 0; i < n; i++) sh[a[11:0] + 12'(pos_of(i, n, big))] = wd[i*8 +: 8];
    @(negedge clk);
    req_valid = 0;
    chk("R2 trap pulse", 32'(trap), 32'(!ok));
    if (!ok) chk("R3 trap_addr", trap_addr, a);
    chk("R9 ld_valid", 32'(ld_valid), 32'(ok && !wr));
    if (ok && !wr) chk(sgn ? "R8/R7 load data" : "R7/R8 load data", ld_data, eld);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_trap;
    void'($urandom(32'd1357));
    for (int i = 0; i < (1<<AW); i++) ram[i] = '0;
    for (int i = 0; i < (4<<AW); i++) sh[i] = '0;
    rst = 1; req_valid = 0; req_write = 0; req_size = 0; req_signed = 0;
    req_big = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ld_valid in reset", 32'(ld_valid), 0);
    chk("R10 trap in reset", 32'(trap), 0);
    chk("R10 trap_addr in reset", trap_addr, 0);
    rst = 0;
    @(negedge clk);
    chk("R10 trap after reset", 32'(trap), 0);
    chk("R10 ld_valid after reset", 32'(ld_valid), 0);

    // directed: word in both orders, readback at other widths
    access(1, 2'b10, 0, 0, 32'h0000_0100, 32'h8899_AABB);
    access(0, 2'b00, 1, 0, 32'h0000_0100, 0);          // BB -> sign-extended R8
    access(0, 2'b00, 0, 0, 32'h0000_0103, 0);          // 88 zero-extended
    access(0, 2'b01, 1, 1, 32'h0000_0102, 0);          // BE half of 99,88 -> 9988 signed
    access(0, 2'b10, 0, 1, 32'h0000_0100, 0);          // R7 byte-swapped view
    access(1, 2'b10, 0, 1, 32'h0000_0200, 32'h1234_7F80);
    access(0, 2'b00, 1, 1, 32'h0000_0200, 0);          // 12 positive
    access(0, 2'b01, 0, 0, 32'h0000_0202, 0);
    // directed misaligned: no write must happen (R2), trap_addr R3
    access(1, 2'b01, 0, 0, 32'hDEAD_0201, 32'hFFFF_FFFF);
    access(1, 2'b10, 0, 1, 32'h0000_0202, 32'hFFFF_FFFF);
    access(1, 2'b10, 0, 0, 32'h0000_0203, 32'hFFFF_FFFF);
    access(0, 2'b11, 0, 0, 32'hCAFE_0200, 0);          // R1 invalid size
    last_trap = 32'hCAFE_0200;
    access(0, 2'b10, 0, 1, 32'h0000_0200, 0);          // unchanged memory R2
    chk("R3 trap_addr held", trap_addr, last_trap);

    for (int it = 0; it < 1500; it++) begin
      logic [31:0] a = {$urandom_range(0, 15) << 28} | 32'($urandom_range(0, 63) + 32'h300);
      access($urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
             $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, $urandom());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule